// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Receiver

This block sits in a PCIe root port and turns message-signalled interrupts into a single interrupt line for the host processor. Downstream devices raise an interrupt by posting a memory write to one programmable 64-bit doorbell address. The data word of that write names a vector. Software then finds the pending vectors through a 32-bit register port and acknowledges them.

Vectors are grouped in banks of 32. Each bank has three 32-bit registers: an enable word, a mask word and a pending-status word. An inbound write that hits the doorbell records a pending bit, but only for an enabled vector. The interrupt line is raised while any pending bit is not masked. Software clears pending bits by writing ones to them. Enabling or disabling one vector is done with a read-modify-write of its bank's enable word.

Top module: `msi_doorbell_rx`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The doorbell address low word is read and written at offset 0x820, and the high word at 0x824. Both hold whatever software wrote.
- R3: Bank n places its enable word at 0x828+12n, its mask word at 0x82C+12n and its status word at 0x830+12n, for n from 0 to 7. Vector v maps to bit v%32 of bank v/32. Enable and mask words read back what was written.
- R4: An inbound write (`in_valid` high) whose 64-bit address equals {high word, low word} sets the status bit of the vector given by the full 32-bit data word, when that vector is enabled. Exactly one bit is set per write, and the mask has no effect on setting.
- R5: An inbound write whose address differs from the doorbell in any bit sets no status.
- R6: An inbound write naming a vector whose enable bit is 0 sets no status. The enable value used is the one held before that clock edge.
- R7: An inbound write whose data word is 256 or more sets no status, including bits whose low-order index would alias.
- R8: Writing a status word clears each bit written as 1 and leaves each bit written as 0. A status write never sets a bit.
- R9: `irq` is high exactly when some status bit is set and its mask bit is 0. It follows the registered state combinationally, so it changes in the cycle after the edge that updates the state.
- R10: When a doorbell hit and a status clear for the same bit occur in the same cycle, the bit ends up set.
- R11: Reads of any offset that is unaligned or outside 0x820..0x887 return zero, and writes to such offsets change nothing.
- R12: `reg_rdata` is loaded on the clock edge where `reg_rd` is high and holds that value until the next read, even if the register changes in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Inbound memory write present |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (vector number) |
| irq | output | 1 | Aggregated interrupt to the host |

## Verification
Two functions can act on the same status bit in one cycle: a doorbell hit that sets it, and a software write-one-to-clear that removes it. The bench provokes this by driving the status write and the inbound write on the same clock edge, first for the same bit and then for different bits of one bank. It then reads the status word back and checks the line. The expected result is that the new set survives while other cleared bits go away. A random mix of enable, mask, clear, doorbell and read operations also makes these events meet by chance, and every outcome is compared against a bench model.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;

    localparam int GRP_BITS  = 32;
    localparam int VEC_W     = 32;
    localparam int GRP_SEL_W = 8;

    typedef logic [GRP_SEL_W-1:0] grp_sel_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_DB_LO,
        RK_DB_HI,
        RK_ENABLE,
        RK_MASK,
        RK_STATUS
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        grp_sel_t  grp;
    } reg_sel_t;

    typedef struct packed {
        logic [GRP_BITS-1:0] en;
        logic [GRP_BITS-1:0] mask;
        logic [GRP_BITS-1:0] stat;
    } grp_state_t;

    typedef struct packed {
        logic [31:0] db_lo;
        logic [31:0] db_hi;
        logic [31:0] rdata;
    } top_state_t;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_rx_pkg::*;
#(
    parameter int             AW         = 12,
    parameter logic [AW-1:0]  BASE       = 12'h820,
    parameter int             NUM_GROUPS = 8
) (
    input  logic [AW-1:0] addr,
    output reg_sel_t      sel
);

    localparam logic [AW-1:0] GRP_BASE = BASE + AW'(8);
    localparam logic [AW-1:0] GRP_SPAN = AW'(NUM_GROUPS * 12);
    localparam logic [AW-1:0] STRIDE   = AW'(12);

    logic [AW-1:0] rel;
    logic [AW-1:0] sub;
    grp_sel_t      grp_idx;

    always_comb begin
        rel      = addr - GRP_BASE;
        grp_idx  = GRP_SEL_W'(rel / STRIDE);
        sub      = rel % STRIDE;
        sel.kind = RK_NONE;
        sel.grp  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == BASE) begin
                sel.kind = RK_DB_LO;
            end else if (addr == BASE + AW'(4)) begin
                sel.kind = RK_DB_HI;
            end else if (addr >= GRP_BASE && rel < GRP_SPAN) begin
                sel.grp = grp_idx;
                if (sub == AW'(0)) begin
                    sel.kind = RK_ENABLE;
                end else if (sub == AW'(4)) begin
                    sel.kind = RK_MASK;
                end else begin
                    sel.kind = RK_STATUS;
                end
            end
        end
    end

endmodule

// File: rtl/msi_vector_group.sv
module msi_vector_group
    import msi_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_enable,
    input  logic                wr_mask,
    input  logic                wr_status,
    input  logic [31:0]         wdata,
    input  logic                set_req,
    input  logic [4:0]          set_bit,
    output logic [GRP_BITS-1:0] enable,
    output logic [GRP_BITS-1:0] mask,
    output logic [GRP_BITS-1:0] status,
    output logic                pend
);

    grp_state_t          st_d, st_q;
    logic [GRP_BITS-1:0] set_vec;
    logic [GRP_BITS-1:0] clr_vec;

    always_comb begin
        st_d    = st_q;
        set_vec = '0;
        if (set_req) begin
            set_vec = (GRP_BITS'(1) << set_bit) & st_q.en;
        end
        clr_vec = wr_status ? wdata : '0;
        if (wr_enable) begin
            st_d.en = wdata;
        end
        if (wr_mask) begin
            st_d.mask = wdata;
        end
        // a fresh set is applied after the clear, so it survives a collision
        st_d.stat = (st_q.stat & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable = st_q.en;
    assign mask   = st_q.mask;
    assign status = st_q.stat;
    assign pend   = |(st_q.stat & ~st_q.mask);

endmodule

// File: rtl/msi_irq_merge.sv
module msi_irq_merge #(
    parameter int N = 8
) (
    input  logic [N-1:0] pend,
    output logic         irq
);

    assign irq = |pend;

endmodule

// File: rtl/msi_doorbell_rx.sv
module msi_doorbell_rx
    import msi_rx_pkg::*;
#(
    parameter int                 NUM_GROUPS = 8,
    parameter int                 REG_AW     = 12,
    parameter logic [REG_AW-1:0]  REG_BASE   = 12'h820
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [63:0]       in_addr,
    input  logic [31:0]       in_data,
    output logic              irq
);

    localparam int               NUM_VEC   = NUM_GROUPS * GRP_BITS;
    localparam logic [VEC_W-1:0] VEC_LIMIT = VEC_W'(NUM_VEC);
    localparam int               VGRP_W    = VEC_W - 5;

    reg_sel_t sel;

    msi_reg_decode #(
        .AW         (REG_AW),
        .BASE       (REG_BASE),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_decode (
        .addr (reg_addr),
        .sel  (sel)
    );

    top_state_t st_d, st_q;

    logic [63:0]       db_addr;
    logic              db_hit;
    logic              vec_ok;
    logic [VGRP_W-1:0] vec_grp;
    logic [4:0]        vec_bit;

    assign db_addr = {st_q.db_hi, st_q.db_lo};
    assign db_hit  = in_valid && (in_addr == db_addr);
    assign vec_ok  = in_data < VEC_LIMIT;
    assign vec_grp = in_data[VEC_W-1:5];
    assign vec_bit = in_data[4:0];

    logic [GRP_BITS-1:0] g_en   [NUM_GROUPS];
    logic [GRP_BITS-1:0] g_mask [NUM_GROUPS];
    logic [GRP_BITS-1:0] g_stat [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] g_pend;
    logic [NUM_VEC-1:0]    en_flat;
    logic [NUM_VEC-1:0]    stat_flat;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        logic sel_here;
        logic wr_e, wr_m, wr_s, set_here;

        assign sel_here = (sel.grp == GRP_SEL_W'(g));
        assign wr_e     = reg_wr && sel_here && (sel.kind == RK_ENABLE);
        assign wr_m     = reg_wr && sel_here && (sel.kind == RK_MASK);
        assign wr_s     = reg_wr && sel_here && (sel.kind == RK_STATUS);
        assign set_here = db_hit && vec_ok && (vec_grp == VGRP_W'(g));

        msi_vector_group u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_enable (wr_e),
            .wr_mask   (wr_m),
            .wr_status (wr_s),
            .wdata     (reg_wdata),
            .set_req   (set_here),
            .set_bit   (vec_bit),
            .enable    (g_en[g]),
            .mask      (g_mask[g]),
            .status    (g_stat[g]),
            .pend      (g_pend[g])
        );

        assign en_flat[g*GRP_BITS +: GRP_BITS]   = g_en[g];
        assign stat_flat[g*GRP_BITS +: GRP_BITS] = g_stat[g];
    end

    msi_irq_merge #(
        .N (NUM_GROUPS)
    ) u_merge (
        .pend (g_pend),
        .irq  (irq)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (sel.kind)
                RK_DB_LO: st_d.db_lo = reg_wdata;
                RK_DB_HI: st_d.db_hi = reg_wdata;
                default:  ;
            endcase
        end
        if (reg_rd) begin
            st_d.rdata = '0;
            case (sel.kind)
                RK_DB_LO: st_d.rdata = st_q.db_lo;
                RK_DB_HI: st_d.rdata = st_q.db_hi;
                default: begin
                    for (int g = 0; g < NUM_GROUPS; g++) begin
                        if (sel.grp == GRP_SEL_W'(g)) begin
                            if (sel.kind == RK_ENABLE) st_d.rdata = g_en[g];
                            if (sel.kind == RK_MASK)   st_d.rdata = g_mask[g];
                            if (sel.kind == RK_STATUS) st_d.rdata = g_stat[g];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;

endmodule

// File: rtl/msi_doorbell_rx_chk.sv
module msi_doorbell_rx_chk #(
    parameter int NUM_VEC = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [63:0]        in_addr,
    input logic [31:0]        in_data,
    input logic               reg_wr,
    input logic [63:0]        db_addr,
    input logic [NUM_VEC-1:0] en_flat,
    input logic [NUM_VEC-1:0] stat_flat,
    input logic               irq
);

    AST_SET_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stat_flat & ~$past(stat_flat)) <= 1); // R4

    AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_flat & ~$past(stat_flat))) |-> ($past(in_valid) && ($past(in_addr) == $past(db_addr)))); // R5

    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_flat & ~$past(stat_flat) & ~$past(en_flat)) == '0)); // R6

    AST_SET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_data) >= 32'(NUM_VEC)) |-> ((stat_flat & ~$past(stat_flat)) == '0)); // R7

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat_flat) & ~stat_flat)) |-> $past(reg_wr)); // R8

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|stat_flat)); // R9

endmodule

bind msi_doorbell_rx msi_doorbell_rx_chk #(
    .NUM_VEC (NUM_GROUPS * 32)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .in_data   (in_data),
    .reg_wr    (reg_wr),
    .db_addr   (db_addr),
    .en_flat   (en_flat),
    .stat_flat (stat_flat),
    .irq       (irq)
);

// File: tb/msi_doorbell_rx_tb.sv
module msi_doorbell_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_en [8];
    logic [31:0] m_mask [8];
    logic [31:0] m_stat [8];
    logic [31:0] m_lo, m_hi;

    always #2 clk = ~clk;

    msi_doorbell_rx u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .in_valid (in_valid), .in_addr (in_addr), .in_data (in_data), .irq (irq)
    );

    function automatic logic [11:0] off(int g, int k);
        return 12'(12'h828 + g * 12 + k * 4);
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int g = 0; g < 8; g++) r |= |(m_stat[g] & ~m_mask[g]);
        return r;
    endfunction

    function automatic void m_inbound(logic [63:0] a, logic [31:0] d);
        if (a == {m_hi, m_lo} && d < 32'd256 && m_en[d[7:5]][d[4:0]])
            m_stat[d[7:5]][d[4:0]] = 1'b1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic db(logic [63:0] a, logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr_and_db(logic [11:0] ra, logic [31:0] rdat, logic [63:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ra; reg_wdata = rdat;
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        reg_wr = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] dba;
        for (int g = 0; g < 8; g++) begin m_en[g] = '0; m_mask[g] = '0; m_stat[g] = '0; end
        m_lo = '0; m_hi = '0;
        void'($urandom(32'd777));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(12'h820, v); chk("R1 db_lo", v, 0);
        for (int g = 0; g < 8; g += 7) begin
            rd(off(g, 0), v); chk("R1 enable", v, 0);
            rd(off(g, 2), v); chk("R1 status", v, 0);
        end

        // R2 doorbell address registers
        m_lo = 32'h8000_0040; m_hi = 32'h0000_0000;
        wr(12'h820, m_lo); wr(12'h824, 32'h0000_0001);
        rd(12'h824, v); chk("R2 db_hi", v, 32'h1);
        wr(12'h824, m_hi);
        rd(12'h820, v); chk("R2 db_lo", v, m_lo);
        dba = {m_hi, m_lo};

        // R3 layout: vector 37 -> bank 1 bit 5, vector 0 -> bank 0 bit 0
        m_en[1] = 32'h0000_0020; wr(off(1, 0), m_en[1]);
        m_en[0] = 32'h0000_0001; wr(off(0, 0), m_en[0]);
        rd(12'h834, v); chk("R3 enable bank1", v, 32'h20);
        wr(12'h838, 32'hA5A5_0000); rd(12'h838, v); chk("R3 mask bank1", v, 32'hA5A5_0000);
        wr(12'h838, 32'h0);

        // R4 doorbell hit sets status, R9 irq follows
        db(dba, 32'd37); m_inbound(dba, 32'd37);
        chk("R9 irq after hit", {31'd0, irq}, 32'd1);
        rd(12'h83C, v); chk("R4 status bank1", v, 32'h20);

        // R9 masking
        wr(12'h838, 32'h20);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        wr(12'h838, 32'h0);
        chk("R9 irq unmasked", {31'd0, irq}, 32'd1);

        // R8 write-one-to-clear
        wr(12'h83C, 32'h0);
        rd(12'h83C, v); chk("R8 zero write keeps", v, 32'h20);
        wr(12'h83C, 32'h20); m_stat[1] = '0;
        rd(12'h83C, v); chk("R8 one write clears", v, 32'h0);
        chk("R8 irq cleared", {31'd0, irq}, 32'd0);
        wr(12'h83C, 32'hFFFF_FFFF);
        rd(12'h83C, v); chk("R8 no set by write", v, 32'h0);

        // R5 address mismatch in high word and low word
        db({32'h1, m_lo}, 32'd37);
        db({m_hi, m_lo ^ 32'h4}, 32'd37);
        rd(12'h83C, v); chk("R5 mismatch dropped", v, 32'h0);

        // R6 disabled vector
        db(dba, 32'd38);
        rd(12'h83C, v); chk("R6 disabled dropped", v, 32'h0);

        // R7 out of range, including aliases of vector 0
        db(dba, 32'd256); db(dba, 32'h0001_0000); db(dba, 32'hFFFF_FFFF);
        rd(off(0, 2), v); chk("R7 alias bank0", v, 32'h0);
        chk("R7 irq", {31'd0, irq}, 32'd0);

        // R10 collision: same bit set and cleared in one cycle
        db(dba, 32'd37); m_inbound(dba, 32'd37);
        wr_and_db(12'h83C, 32'h20, dba, 32'd37);
        rd(12'h83C, v); chk("R10 set wins", v, 32'h20);
        m_en[1] = 32'h0000_0060; wr(off(1, 0), m_en[1]);
        wr_and_db(12'h83C, 32'h20, dba, 32'd38);
        m_stat[1] = 32'h40;
        rd(12'h83C, v); chk("R10 other bit cleared", v, 32'h40);
        chk("R10 irq", {31'd0, irq}, 32'd1);
        wr(12'h83C, 32'h40); m_stat[1] = '0;

        // R11 unimplemented offsets
        wr(12'h82A, 32'hFFFF_FFFF); wr(12'h888, 32'hFFFF_FFFF); wr(12'h81C, 32'hFFFF_FFFF);
        rd(off(0, 0), v); chk("R11 enable untouched", v, m_en[0]);
        rd(12'h888, v); chk("R11 past end", v, 0);
        rd(12'h829, v); chk("R11 unaligned", v, 0);
        rd(12'h7FC, v); chk("R11 below", v, 0);

        // R12 read data is held
        rd(12'h820, v);
        wr(12'h820, 32'h1234_5678);
        chk("R12 rdata held", reg_rdata, m_lo);
        wr(12'h820, m_lo);

        // random phase with a 64-bit doorbell
        m_hi = 32'h0000_0003; wr(12'h824, m_hi); dba = {m_hi, m_lo};
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 6);
            int g  = $urandom_range(0, 7);
            logic [31:0] d = $urandom();
            case (op)
                0: begin m_en[g] = d; wr(off(g, 0), d); end
                1: begin d = d & $urandom() & $urandom(); m_mask[g] = d; wr(off(g, 1), d); end
                2, 3: begin
                    logic [63:0] a = dba;
                    logic [31:0] vec = $urandom_range(0, 300);
                    if ($urandom_range(0, 4) == 0) a = a ^ (64'd1 << $urandom_range(0, 63));
                    m_inbound(a, vec); db(a, vec);
                end
                4: begin m_stat[g] &= ~d; wr(off(g, 2), d); end
                5: begin
                    logic [31:0] vec = $urandom_range(0, 255);
                    m_stat[vec[7:5]] &= ~d;
                    m_inbound(dba, vec);
                    wr_and_db(off(int'(vec[7:5]), 2), d, dba, vec);
                end
                default: begin
                    int k = $urandom_range(0, 2);
                    rd(off(g, k), v);
                    chk("R3 random read", v, k == 0 ? m_en[g] : (k == 1 ? m_mask[g] : m_stat[g]));
                end
            endcase
            chk("R9 random irq", {31'd0, irq}, {31'd0, exp_irq()});
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule